// File: doc/BRIEF.md
# Protocol Discovery Responder

This block serves the discovery request of a data-object mailbox. When the mailbox controller pulses `start`, the responder captures the first three dwords of the pending request. It checks that the header names the discovery object and that the declared length is large enough. It then looks up the requested index in a table of supported protocols that is supplied on an input port. Each table entry packs a 16-bit vendor identifier in its low bits and an 8-bit object type above it.

For an accepted request, the block writes a three-dword response object into the read mailbox through a dword-write port. The first two dwords form a fixed header. The third dword names the protocol found at the requested index and gives the index software should ask for next. Software therefore walks the whole list by starting at index 0 and following the returned next index until it wraps back to 0. For a rejected request, nothing is written. In both cases the block ends with a one-cycle completion flag paired with either a success or a discard flag.

Let N be the number of table entries plus one. Index 0 always describes discovery itself, table entries appear at indices 1 to N-1, and the next index wraps modulo N.

Top module: `disc_responder`

## Requirements
- R1: A request whose dword 0 differs from 32'h0000_0001 (vendor 0x0001 in bits 15:0, object type 0x00 in bits 23:16, zero above) is discarded and produces no write.
- R2: The request length is bits 17:0 of dword 1. When it is below 3, the request is discarded with no write; bits above 17 are ignored.
- R3: An accepted request writes exactly three dwords at indices 0, 1, 2 on consecutive cycles. Dword 0 is 32'h0000_0001 and dword 1 is 32'd3.
- R4: Response dword 2 carries the vendor in bits 15:0, the object type in bits 23:16 and the next index in bits 31:24.
- R5: Requested index 0 (bits 7:0 of request dword 2) reports vendor 0x0001 and type 0x00.
- R6: A requested index i with 1 <= i <= N-1 reports table entry i-1, where entry k occupies bits 24k+23:24k of `protoTable`.
- R7: A requested index of N or more reports vendor 0xFFFF and type 0xFF.
- R8: The next index is (index + 1) modulo N, computed without truncating index + 1 to 8 bits, so the last valid index returns 0.
- R9: `done` is high for exactly one cycle, four clock edges after the edge that samples `start`. While `done` is high, exactly one of `ok` and `discard` is high, and `ok` is high precisely for an accepted request.
- R10: `start` is ignored while a request is in progress. Request inputs that change after the sampling edge do not alter the response.
- R11: In reset and directly after it, `done`, `ok`, `discard` and `wrEn` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin serving the request presented on the request dwords |
| reqDw0 | input | 32 | Request dword 0 (object identifier) |
| reqDw1 | input | 32 | Request dword 1 (length in bits 17:0) |
| reqDw2 | input | 32 | Request dword 2 (index in bits 7:0) |
| protoTable | input | 24*NUM_PROTO | Supported protocols, entry k at bits 24k+23:24k as {type, vendor} |
| wrEn | output | 1 | Response dword write strobe |
| wrIdx | output | 2 | Dword position of the write within the response |
| wrData | output | 32 | Response dword |
| done | output | 1 | One-cycle completion flag |
| ok | output | 1 | Request served, with `done` |
| discard | output | 1 | Request dropped, with `done` |

## Verification
The bench sends requests for index 0, a middle table index, the last valid index, the first out-of-range index and index 255. These separate the fixed discovery answer, the offset-by-one table lookup, the all-ones answer, and the modulo wrap of the next index, including the case where index + 1 overflows eight bits. Two length values that share the same bits 17:0 but differ above bit 17 show whether the length field is masked correctly. A value of exactly 3 marks the accept boundary, and a foreign object identifier must be dropped. One request holds `start` high and changes the index after sampling, which shows whether the responder restarts or re-reads its inputs.

// File: rtl/disc_pkg.sv
package disc_pkg;
  localparam int DW       = 32;
  localparam int VEND_W   = 16;
  localparam int TYPE_W   = 8;
  localparam int ENTRY_W  = VEND_W + TYPE_W;
  localparam int IDX_W    = 8;
  localparam int LEN_W    = 18;
  localparam int RSP_LEN  = 3;

  localparam logic [VEND_W-1:0] SIG_VENDOR = 16'h0001;
  localparam logic [TYPE_W-1:0] DISC_TYPE  = 8'h00;
  localparam logic [DW-1:0]     DISC_ID    = {8'h00, DISC_TYPE, SIG_VENDOR};

  typedef enum logic [1:0] {ST_IDLE, ST_BEAT, ST_FIN} state_t;

  typedef struct packed {
    logic       capture;
    logic [1:0] beat;
  } strobe_t;
endpackage

// File: rtl/disc_ctrl.sv
module disc_ctrl
  import disc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       reqOk,
  output strobe_t    strobe,
  output logic       wrEn,
  output logic [1:0] wrIdx,
  output logic       done,
  output logic       ok,
  output logic       discard
);
  localparam logic [1:0] LAST_BEAT = 2'(RSP_LEN - 1);

  state_t     state;
  logic [1:0] beat;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      beat  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_BEAT;
          beat  <= '0;
        end
        ST_BEAT: if (beat == LAST_BEAT) state <= ST_FIN;
                 else beat <= beat + 2'd1;
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.capture = (state == ST_IDLE) && start;
    strobe.beat    = beat;
    wrEn           = (state == ST_BEAT) && reqOk;
    wrIdx          = beat;
    done           = (state == ST_FIN);
    ok             = done && reqOk;
    discard        = done && !reqOk;
  end

  AST_DONE_ONE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($countones({ok, discard}) == 1)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(strobe.capture, 4)); // R9
  AST_WR_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrIdx != 2'd0) |-> ($past(wrEn) && $past(wrIdx) == wrIdx - 2'd1)); // R3
  AST_NO_WR_ON_DISCARD: assert property (@(posedge clk) disable iff (!rstN)
    discard |-> !$past(wrEn)); // R1
endmodule

// File: rtl/disc_dp.sv
module disc_dp
  import disc_pkg::*;
#(
  parameter int NUM_PROTO = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      strobe,
  input  logic [DW-1:0]                reqDw0,
  input  logic [DW-1:0]                reqDw1,
  input  logic [DW-1:0]                reqDw2,
  input  logic [NUM_PROTO*ENTRY_W-1:0] protoTable,
  output logic                         reqOk,
  output logic [DW-1:0]                wrData
);
  localparam int TOTAL = NUM_PROTO + 1;
  localparam logic [IDX_W:0] TOTAL_W = (IDX_W+1)'(TOTAL);

  logic [IDX_W-1:0]  capIdx;
  logic [VEND_W-1:0] entVendor;
  logic [TYPE_W-1:0] entType;
  logic [IDX_W:0]    incIdx;
  logic [IDX_W:0]    wrapIdx;
  logic [IDX_W-1:0]  nextIdx;
  logic              unusedBits;

  assign unusedBits = ^{reqDw1[DW-1:LEN_W], reqDw2[DW-1:IDX_W]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqOk  <= 1'b0;
      capIdx <= '0;
    end else if (strobe.capture) begin
      reqOk  <= (reqDw0 == DISC_ID) && (reqDw1[LEN_W-1:0] >= LEN_W'(RSP_LEN));
      capIdx <= reqDw2[IDX_W-1:0];
    end
  end

  always_comb begin
    if (capIdx == '0) begin
      entVendor = SIG_VENDOR;
      entType   = DISC_TYPE;
    end else begin
      entVendor = '1;
      entType   = '1;
    end
    for (int k = 0; k < NUM_PROTO; k++) begin
      if (capIdx == IDX_W'(k + 1)) begin
        entVendor = protoTable[k*ENTRY_W +: VEND_W];
        entType   = protoTable[k*ENTRY_W + VEND_W +: TYPE_W];
      end
    end
    incIdx  = {1'b0, capIdx} + (IDX_W+1)'(1);
    wrapIdx = incIdx % TOTAL_W;
    nextIdx = wrapIdx[IDX_W-1:0];
  end

  always_comb begin
    unique case (strobe.beat)
      2'd0:    wrData = DISC_ID;
      2'd1:    wrData = DW'(RSP_LEN);
      2'd2:    wrData = {nextIdx, entType, entVendor};
      default: wrData = '0;
    endcase
  end

  AST_NEXT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.beat == 2'd2) |-> ({1'b0, wrData[31:24]} < TOTAL_W)); // R8
  AST_OOR_ALL_ONES: assert property (@(posedge clk) disable iff (!rstN)
    ((strobe.beat == 2'd2) && ({1'b0, capIdx} >= TOTAL_W)) |-> (wrData[23:0] == 24'hFFFFFF)); // R7
  AST_IDX0_SELF: assert property (@(posedge clk) disable iff (!rstN)
    ((strobe.beat == 2'd2) && (capIdx == '0)) |-> (wrData[23:0] == {DISC_TYPE, SIG_VENDOR})); // R5
  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(capIdx)); // R10
endmodule

// File: rtl/disc_responder.sv
module disc_responder
  import disc_pkg::*;
#(
  parameter int NUM_PROTO = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         start,
  input  logic [31:0]                  reqDw0,
  input  logic [31:0]                  reqDw1,
  input  logic [31:0]                  reqDw2,
  input  logic [NUM_PROTO*24-1:0]      protoTable,
  output logic                         wrEn,
  output logic [1:0]                   wrIdx,
  output logic [31:0]                  wrData,
  output logic                         done,
  output logic                         ok,
  output logic                         discard
);
  strobe_t strobe;
  logic    reqOk;

  disc_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .reqOk(reqOk), .strobe(strobe),
    .wrEn(wrEn), .wrIdx(wrIdx), .done(done), .ok(ok), .discard(discard)
  );

  disc_dp #(.NUM_PROTO(NUM_PROTO)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqDw0(reqDw0), .reqDw1(reqDw1),
    .reqDw2(reqDw2), .protoTable(protoTable), .reqOk(reqOk), .wrData(wrData)
  );

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk)
    !rstN |=> (!done && !wrEn)); // R11
endmodule

// File: tb/tb_disc_responder.sv
module tb_disc_responder;
  localparam int NP = 3;
  localparam int NT = NP + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [31:0] reqDw0 = '0, reqDw1 = '0, reqDw2 = '0;
  logic [NP*24-1:0] protoTable;
  logic wrEn, done, ok, discard;
  logic [1:0] wrIdx;
  logic [31:0] wrData;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [33:0] expWords[$];
  string       expTags[$];
  logic [1:0]  expOut[$];

  always #10 clk = ~clk;

  assign protoTable = {8'h05, 16'hABCD, 8'h02, 16'h1E98, 8'h01, 16'h0001};

  disc_responder #(.NUM_PROTO(NP)) dut (
    .clk(clk), .rstN(rstN), .start(start), .reqDw0(reqDw0), .reqDw1(reqDw1),
    .reqDw2(reqDw2), .protoTable(protoTable), .wrEn(wrEn), .wrIdx(wrIdx),
    .wrData(wrData), .done(done), .ok(ok), .discard(discard)
  );

  task automatic check(input bit cond, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expDw2(input int idx);
    logic [15:0] v;
    logic [7:0]  t;
    if (idx == 0) begin v = 16'h0001; t = 8'h00; end
    else if (idx < NT) begin
      v = protoTable[(idx-1)*24 +: 16];
      t = protoTable[(idx-1)*24 + 16 +: 8];
    end else begin v = 16'hFFFF; t = 8'hFF; end
    return {8'((idx + 1) % NT), t, v};
  endfunction

  // Monitor
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (wrEn) begin
        if (expWords.size() == 0) begin
          check(0, "R1/R2 unexpected write", {30'd0, wrIdx, wrData}, 64'd0);
        end else begin
          logic [33:0] e;
          string tg;
          e = expWords.pop_front();
          tg = expTags.pop_front();
          check({wrIdx, wrData} == e, tg, {30'd0, wrIdx, wrData}, {30'd0, e});
        end
      end
      if (done) begin
        if (expOut.size() == 0) check(0, "R9 unexpected done", 64'd1, 64'd0);
        else begin
          logic [1:0] eo;
          eo = expOut.pop_front();
          check({ok, discard} == eo, "R9 outcome", {62'd0, ok, discard}, {62'd0, eo});
          check(expWords.size() == 0, "R3 missing words", expWords.size(), 64'd0);
        end
      end
    end
  end

  task automatic send(input logic [31:0] d0, input logic [31:0] d1, input int idx,
                      input bit accept, input string tag, input bit hold);
    @(negedge clk);
    reqDw0 = d0; reqDw1 = d1; reqDw2 = 32'hA5A5_A500 | 32'(idx[7:0]);
    if (accept) begin
      expWords.push_back({2'd0, 32'h0000_0001}); expTags.push_back("R3 dword0");
      expWords.push_back({2'd1, 32'd3});         expTags.push_back("R3 dword1");
      expWords.push_back({2'd2, expDw2(idx)});   expTags.push_back(tag);
    end
    expOut.push_back(accept ? 2'b10 : 2'b01);
    start = 1'b1;
    @(negedge clk);
    if (hold) reqDw2 = 32'h0000_0002;   // R10 change after sampling
    else start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(done == 1'b0, "R9 early done", {63'd0, done}, 64'd0);
    @(negedge clk);
    check(done == 1'b1, "R9 done latency", {63'd0, done}, 64'd1);
    start = 1'b0;
    @(negedge clk);
    check(done == 1'b0 && wrEn == 1'b0, "R10 no restart", {62'd0, done, wrEn}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!done && !ok && !discard && !wrEn, "R11 in reset", {60'd0, done, ok, discard, wrEn}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(!done && !wrEn, "R11 after reset", {62'd0, done, wrEn}, 64'd0);

    send(32'h0000_0001, 32'd3, 0, 1, "R5 index0", 0);
    send(32'h0000_0001, 32'd3, 2, 1, "R6 middle entry", 0);
    send(32'h0000_0001, 32'd3, 3, 1, "R8 last wraps", 0);
    send(32'h0000_0001, 32'd8, 1, 1, "R4 first entry", 0);
    send(32'h0000_0001, 32'd3, 4, 1, "R7 first out of range", 0);
    send(32'h0000_0001, 32'd3, 255, 1, "R8 index255 wrap", 0);
    send(32'h0000_0001, 32'd2, 1, 0, "R2 short", 0);
    send(32'h0000_0001, 32'h0004_0002, 1, 0, "R2 masked short", 0);
    send(32'h0000_0001, 32'h0004_0003, 1, 1, "R2 masked ok", 0);
    send(32'h0001_0001, 32'd3, 0, 0, "R1 wrong id", 0);
    send(32'h0000_0001, 32'd3, 3, 1, "R10 held start", 1);

    repeat (4) @(negedge clk);
    check(expOut.size() == 0, "R9 pending outcomes", expOut.size(), 64'd0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL R9 watchdog expired actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule